// File: doc/BRIEF.md
# Block Address Translation Matcher

This block translates a 32-bit effective address to a physical address for large, naturally aligned blocks, from 128 KB up to 256 MB. It holds a small bank of translation entries (four by default). Each entry is a pair of 32-bit words. The upper word gives the effective block index, a thin block-length mask and two valid bits, one for supervisor state and one for user state. The lower word gives the real block index, four cache attribute bits and a 2-bit protection code.

Software loads the entries through a one-cycle register-write port. Each lookup presents an address, a privilege flag and a read/write flag. One cycle later the block returns a hit with the translated address and the attributes, a protection fault, or a miss. On a miss the caller falls back to ordinary page translation.

Top module: `blk_xlat`

## Requirements
- R1: Synchronous active-low reset clears every entry so that nothing hits, and clears all outputs to zero.
- R2: With `cfg_we` high at a clock edge, `cfg_wdata` is stored into entry `cfg_idx`: the upper word when `cfg_hi` is 1, the lower word when it is 0. Lookup results are registered. A lookup in the cycle of a write still sees the old contents, and the new contents apply from the next cycle.
- R3: The upper word is laid out as follows: bits 31:17 hold the effective block index, bits 12:2 the length mask, bit 1 the supervisor valid bit and bit 0 the user valid bit. An entry matches when address bits 31:17 equal the index in every bit position that the mask does not cover.
- R4: Mask bit k covers address bit 17+k. A mask of 0x000 gives a 128 KB block, 0x007 gives 1 MB and 0x7FF gives 256 MB.
- R5: A lookup with `lk_super`=1 uses the supervisor valid bit and one with `lk_super`=0 uses the user valid bit. An entry whose bit for the current state is clear never matches.
- R6: On a hit, the translated address takes bits 16:0 and the mask-covered bits from the effective address. The remaining bits of 31:17 come from the real block index, which is held in bits 31:17 of the lower word.
- R7: The lower word holds the attributes in bits 6:3 (write-through, cache-inhibit, coherent, guarded, from bit 6 down) and the protection code in bits 1:0. On a hit, `xl_attr` carries bits 6:3 of the winning entry.
- R8: When several entries match, the entry with the lowest number wins.
- R9: Protection code 0 faults on any access and code 1 faults on a write. Codes 2 and 3 allow reads and writes. A fault raises `xl_fault` and deasserts `xl_hit`.
- R10: When no entry matches, `xl_hit` and `xl_fault` are both 0. Whenever `xl_hit` is 0, `xl_paddr` and `xl_attr` are 0.
- R11: `xl_hit` and `xl_fault` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Entry write strobe |
| cfg_idx | input | 2 | Entry number to write |
| cfg_hi | input | 1 | 1 selects the upper word, 0 the lower word |
| cfg_wdata | input | 32 | Word to write |
| lk_addr | input | 32 | Effective address to translate |
| lk_super | input | 1 | 1 for supervisor state, 0 for user state |
| lk_write | input | 1 | 1 for a write access, 0 for a read |
| xl_hit | output | 1 | Registered: translation succeeded |
| xl_paddr | output | 32 | Registered translated address |
| xl_attr | output | 4 | Registered cache attributes of the winning entry |
| xl_fault | output | 1 | Registered protection fault |

## Verification
The hardest situation to reach is one where two entries of different sizes cover the same address and differ in their privilege valid bits. In that case the winner depends on both the priority order and the privilege flag. The stimulus loads a small 128 KB supervisor-only entry at a lower number, inside a larger 1 MB entry valid for both states. It then probes one address in both states and probes addresses just outside the small block. Overlapping a write with a lookup in the same cycle shows the one-cycle boundary at which new contents take effect.

// File: rtl/blk_xlat_pkg.sv
// Package: shared widths, entry word types and the decoders that turn a
// written 32-bit word into an entry field set.
// Assumes a 32-bit address and a fixed 128 KB minimum block.
package blk_xlat_pkg;

    localparam int ADDR_W = 32;
    localparam int IDX_W  = 15;                  // block index width
    localparam int MASK_W = 11;                  // length mask width
    localparam int OFS_W  = ADDR_W - IDX_W;      // always-passed offset bits
    localparam int ATTR_W = 4;
    localparam int ATTR_LSB = 3;

    typedef enum logic [1:0] {
        PROT_NONE = 2'd0,
        PROT_RO   = 2'd1,
        PROT_RW   = 2'd2,
        PROT_RW2  = 2'd3
    } prot_e;

    typedef struct packed {
        logic [IDX_W-1:0]  eidx;
        logic [MASK_W-1:0] len_mask;
        logic              sup_ok;
        logic              usr_ok;
    } upper_t;

    typedef struct packed {
        logic [IDX_W-1:0]  ridx;
        logic [ATTR_W-1:0] attr;
        prot_e             prot;
    } lower_t;

    // Decode an upper word into its fields.
    function automatic upper_t dec_upper(input logic [ADDR_W-1:0] w);
        upper_t u;
        u.eidx     = w[ADDR_W-1 -: IDX_W];
        u.len_mask = w[MASK_W+1:2];
        u.sup_ok   = w[1];
        u.usr_ok   = w[0];
        return u;
    endfunction

    // Decode a lower word into its fields.
    function automatic lower_t dec_lower(input logic [ADDR_W-1:0] w);
        lower_t l;
        l.ridx = w[ADDR_W-1 -: IDX_W];
        l.attr = w[ATTR_LSB+ATTR_W-1:ATTR_LSB];
        l.prot = prot_e'(w[1:0]);
        return l;
    endfunction

endpackage

// File: rtl/blk_xlat_regs.sv
// Entry storage: holds the decoded upper and lower word of each entry and
// loads one of them per cycle from the write port.
// Assumes cfg_idx is below N_ENTRY; reset leaves every entry invalid.
module blk_xlat_regs
    import blk_xlat_pkg::*;
#(
    parameter int N_ENTRY = 4,
    localparam int SEL_W  = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_idx,
    input  logic              cfg_hi,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output upper_t            up_q [N_ENTRY],
    output lower_t            lo_q [N_ENTRY]
);

    for (genvar e = 0; e < N_ENTRY; e++) begin : g_ent
        // Load the upper word of this entry when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                up_q[e] <= '0;
            else if (cfg_we && cfg_hi && (cfg_idx == SEL_W'(e)))
                up_q[e] <= dec_upper(cfg_wdata);
        end

        // Load the lower word of this entry when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lo_q[e] <= '0;
            else if (cfg_we && !cfg_hi && (cfg_idx == SEL_W'(e)))
                lo_q[e] <= dec_lower(cfg_wdata);
        end
    end

    // R2
    wr_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_hi) |=> (up_q[$past(cfg_idx)] == dec_upper($past(cfg_wdata))));

    // R2
    wr_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_hi) |=> (lo_q[$past(cfg_idx)] == dec_lower($past(cfg_wdata))));

endmodule

// File: rtl/blk_xlat_match.sv
// One entry's comparator: decides whether the address falls in the entry's
// block for the current privilege and forms the translated block index.
// Purely combinational; assumes the mask is a thin mask (ones from bit 0).
module blk_xlat_match
    import blk_xlat_pkg::*;
(
    input  upper_t            up,
    input  lower_t            lo,
    input  logic [IDX_W-1:0]  ea_idx,
    input  logic              is_super,
    output logic              hit,
    output logic [IDX_W-1:0]  pa_idx
);

    logic [IDX_W-1:0] keep;   // index bits that take part in the compare
    logic             priv_ok;

    // Bits not covered by the mask are compared and taken from the real index.
    always_comb keep = ~{{(IDX_W-MASK_W){1'b0}}, up.len_mask};

    // Match on privilege-valid plus masked index equality; build the output index.
    always_comb begin
        priv_ok = is_super ? up.sup_ok : up.usr_ok;
        hit     = priv_ok && (((ea_idx ^ up.eidx) & keep) == '0);
        pa_idx  = (lo.ridx & keep) | (ea_idx & ~keep);
    end

endmodule

// File: rtl/blk_xlat_select.sv
// Winner selection and result register: picks the lowest-numbered matching
// entry, applies its protection code and registers hit/fault/address/attrs.
// Assumes candidate vectors arrive from the same cycle's address.
module blk_xlat_select
    import blk_xlat_pkg::*;
#(
    parameter int N_ENTRY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_ENTRY-1:0] cand,
    input  logic [IDX_W-1:0]  cand_pa [N_ENTRY],
    input  lower_t            lo_q   [N_ENTRY],
    input  logic [OFS_W-1:0]  ea_ofs,
    input  logic              is_write,
    output logic              xl_hit,
    output logic [ADDR_W-1:0] xl_paddr,
    output logic [ATTR_W-1:0] xl_attr,
    output logic              xl_fault
);

    logic             found;
    lower_t           win_lo;
    logic [IDX_W-1:0] win_pa;
    logic             denied;

    // Priority pick: scan high to low so the lowest match is kept last.
    always_comb begin
        found  = 1'b0;
        win_lo = '0;
        win_pa = '0;
        for (int e = N_ENTRY - 1; e >= 0; e--) begin
            if (cand[e]) begin
                found  = 1'b1;
                win_lo = lo_q[e];
                win_pa = cand_pa[e];
            end
        end
    end

    // Protection check of the winner against the access direction.
    always_comb
        denied = (win_lo.prot == PROT_NONE) || ((win_lo.prot == PROT_RO) && is_write);

    // Register the lookup result; everything but a clean hit zeroes address and attrs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xl_hit   <= 1'b0;
            xl_fault <= 1'b0;
            xl_paddr <= '0;
            xl_attr  <= '0;
        end else begin
            xl_hit   <= found && !denied;
            xl_fault <= found && denied;
            xl_paddr <= (found && !denied) ? {win_pa, ea_ofs} : '0;
            xl_attr  <= (found && !denied) ? win_lo.attr : '0;
        end
    end

    // R11
    hit_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({xl_hit, xl_fault}));

    // R10
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xl_hit |-> (xl_paddr == '0 && xl_attr == '0));

    // R6
    ofs_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xl_hit |-> (xl_paddr[OFS_W-1:0] == $past(ea_ofs)));

    // R10
    no_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cand == '0) |=> (!xl_hit && !xl_fault));

endmodule

// File: rtl/blk_xlat.sv
// Top of the block address translation matcher: entry storage, one
// comparator per entry, and the priority/protection result stage.
// Results appear one clock after the lookup inputs are presented.
module blk_xlat
    import blk_xlat_pkg::*;
#(
    parameter int N_ENTRY = 4,
    localparam int SEL_W  = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_idx,
    input  logic              cfg_hi,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              lk_super,
    input  logic              lk_write,
    output logic              xl_hit,
    output logic [ADDR_W-1:0] xl_paddr,
    output logic [ATTR_W-1:0] xl_attr,
    output logic              xl_fault
);

    upper_t            up_q    [N_ENTRY];
    lower_t            lo_q    [N_ENTRY];
    logic [N_ENTRY-1:0] cand;
    logic [IDX_W-1:0]  cand_pa [N_ENTRY];

    blk_xlat_regs #(.N_ENTRY(N_ENTRY)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_hi    (cfg_hi),
        .cfg_wdata (cfg_wdata),
        .up_q      (up_q),
        .lo_q      (lo_q)
    );

    for (genvar e = 0; e < N_ENTRY; e++) begin : g_cmp
        blk_xlat_match u_match (
            .up       (up_q[e]),
            .lo       (lo_q[e]),
            .ea_idx   (lk_addr[ADDR_W-1 -: IDX_W]),
            .is_super (lk_super),
            .hit      (cand[e]),
            .pa_idx   (cand_pa[e])
        );
    end

    blk_xlat_select #(.N_ENTRY(N_ENTRY)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .cand     (cand),
        .cand_pa  (cand_pa),
        .lo_q     (lo_q),
        .ea_ofs   (lk_addr[OFS_W-1:0]),
        .is_write (lk_write),
        .xl_hit   (xl_hit),
        .xl_paddr (xl_paddr),
        .xl_attr  (xl_attr),
        .xl_fault (xl_fault)
    );

    // R9
    ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cand[0] && lk_write && lo_q[0].prot == PROT_RO) |=> (xl_fault && !xl_hit));

endmodule

// File: tb/blk_xlat_bench.sv
module blk_xlat_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we, cfg_hi;
    logic [1:0]  cfg_idx;
    logic [31:0] cfg_wdata, lk_addr;
    logic        lk_super, lk_write;
    logic        xl_hit, xl_fault;
    logic [31:0] xl_paddr;
    logic [3:0]  xl_attr;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #10 clk = ~clk;   // 50 MHz

    blk_xlat u_blk_xlat (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_hi(cfg_hi), .cfg_wdata(cfg_wdata), .lk_addr(lk_addr),
        .lk_super(lk_super), .lk_write(lk_write), .xl_hit(xl_hit),
        .xl_paddr(xl_paddr), .xl_attr(xl_attr), .xl_fault(xl_fault)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic        sup;
        logic        wr;
        logic        e_hit;
        logic        e_fault;
        logic [31:0] e_pa;
        logic [3:0]  e_attr;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{32'h1000_1234, 1'b1, 1'b0, 1'b1, 1'b0, 32'h8000_1234, 4'hA}, // R8 entry 0 beats entry 2
        '{32'h1000_1234, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0030_1234, 4'h3}, // R5 user skips entry 0
        '{32'h1002_0000, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0032_0000, 4'h3}, // R4 past 128K, inside 1M
        '{32'h100F_FFFC, 1'b0, 1'b1, 1'b1, 1'b0, 32'h003F_FFFC, 4'h3}, // R6 mask bits from address
        '{32'h1010_0000, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0,         4'h0}, // R10 just past 1M
        '{32'h2ABC_DEF0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h4ABC_DEF0, 4'h5}, // R4 256M block, R7 attrs
        '{32'h2ABC_DEF0, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0,         4'h0}, // R9 write to read-only
        '{32'h2FFF_FFFF, 1'b1, 1'b0, 1'b1, 1'b0, 32'h4FFF_FFFF, 4'h5}, // R6 top of 256M block
        '{32'h3000_0010, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0,         4'h0}, // R9 no-access read
        '{32'h3002_0000, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0,         4'h0}, // R3 index differs
        '{32'h0000_0000, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0,         4'h0}, // R10 miss
        '{32'h301F_FFFF, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0,         4'h0}  // R3 outside 128K
    };

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    task automatic check(input string req, input logic eh, input logic ef,
                         input logic [31:0] ep, input logic [3:0] ea);
        n_chk++;
        if (xl_hit !== eh || xl_fault !== ef || xl_paddr !== ep || xl_attr !== ea) begin
            n_err++;
            $display("FAIL %s: hit=%0b fault=%0b pa=%h attr=%h expected hit=%0b fault=%0b pa=%h attr=%h",
                     req, xl_hit, xl_fault, xl_paddr, xl_attr, eh, ef, ep, ea);
        end
    endtask

    task automatic wr_word(input logic [1:0] idx, input logic hi, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_hi = hi; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic look(input logic [31:0] a, input logic s, input logic w);
        @(negedge clk);
        lk_addr = a; lk_super = s; lk_write = w;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: run did not finish, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_hi = 1'b0; cfg_wdata = '0;
        lk_addr = 32'h1000_1234; lk_super = 1'b1; lk_write = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 outputs in reset", 1'b0, 1'b0, 32'h0, 4'h0);
        @(negedge clk);
        rst_n = 1'b1;
        look(32'h1000_1234, 1'b1, 1'b0);
        check("R1 cleared entries miss", 1'b0, 1'b0, 32'h0, 4'h0);

        // Entry load (R2, R3, R7 word layouts)
        wr_word(2'd0, 1'b1, 32'h1000_0002);  // 128K, supervisor only
        wr_word(2'd0, 1'b0, 32'h8000_0052);  // attr A, read/write
        wr_word(2'd1, 1'b1, 32'h2000_1FFF);  // 256M, both states
        wr_word(2'd1, 1'b0, 32'h4000_0029);  // attr 5, read-only
        wr_word(2'd2, 1'b1, 32'h1000_001F);  // 1M, both states
        wr_word(2'd2, 1'b0, 32'h0030_001A);  // attr 3, read/write
        wr_word(2'd3, 1'b1, 32'h3000_0003);  // 128K, both states
        wr_word(2'd3, 1'b0, 32'h0A00_0000);  // no access

        for (int i = 0; i < NV; i++) begin
            look(VECS[i].addr, VECS[i].sup, VECS[i].wr);
            check($sformatf("R3-R10 vector %0d", i), VECS[i].e_hit, VECS[i].e_fault,
                  VECS[i].e_pa, VECS[i].e_attr);
        end

        // R2: write and lookup in the same cycle see the old contents first
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 2'd3; cfg_hi = 1'b0; cfg_wdata = 32'h0A00_0002;
        lk_addr = 32'h3000_0010; lk_super = 1'b1; lk_write = 1'b0;
        @(posedge clk);
        #1;
        check("R2 same-cycle lookup uses old entry", 1'b0, 1'b1, 32'h0, 4'h0);
        @(negedge clk);
        cfg_we = 1'b0;
        @(posedge clk);
        #1;
        check("R2 new entry next cycle", 1'b1, 1'b0, 32'h0A00_0010, 4'h0);

        // R9: protection code 3 allows a write
        wr_word(2'd3, 1'b0, 32'h0A00_0003);
        look(32'h3000_0010, 1'b1, 1'b1);
        check("R9 code 3 write allowed", 1'b1, 1'b0, 32'h0A00_0010, 4'h0);

        // R5: clearing the user bit hides entry 1 from user state only
        wr_word(2'd1, 1'b1, 32'h2000_1FFE);
        look(32'h2ABC_DEF0, 1'b0, 1'b0);
        check("R5 user bit clear misses", 1'b0, 1'b0, 32'h0, 4'h0);
        look(32'h2ABC_DEF0, 1'b1, 1'b0);
        check("R5 supervisor still hits", 1'b1, 1'b0, 32'h4ABC_DEF0, 4'h5);

        // R1: reset in mid-run clears entries
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1 outputs after mid-run reset", 1'b0, 1'b0, 32'h0, 4'h0);
        @(negedge clk);
        rst_n = 1'b1;
        look(32'h2ABC_DEF0, 1'b1, 1'b0);
        check("R1 entries cleared by reset", 1'b0, 1'b0, 32'h0, 4'h0);

        done = 1;
        summary();
        $finish;
    end

endmodule